// File: doc/BRIEF.md
# Dual-Rate Operand Read/Write Sequencer

This block is the control core of one compute cell that holds two groups of three processing elements. A master section takes one instruction per slow cycle and hands the same operation to every element of a group. Two slave sequencers, one per group, run at twice the instruction rate. Each owns a synchronous memory port. In the first half of a slow cycle it reads the operand word for the newest instruction. In the second half it writes back the result word of an instruction issued two slow cycles earlier. Memory traffic therefore hides behind the arithmetic of the instruction in flight.

The design uses one fast clock. An internal phase bit splits each slow cycle into a fetch half (tick low) and a store half (tick high), and the master registers advance only at the end of the store half. An instruction carries a source address, a destination address and an operation code for each group. A mode bit chooses between two ways of using them. In shared mode both groups take group 0's fields. In independent mode each group takes its own fields. The elements see a three-lane operand word and return a three-lane result word. Decoding the operation and the arithmetic itself lie outside this block.

Top module: `opseq_dual_rate`

## Requirements
- R1: `mstr_tick` is low while `rst_n` is low and for the first two clock cycles after `rst_n` rises. It is high in the third cycle and then toggles every cycle. A slow cycle is a tick-low cycle followed by a tick-high cycle, and the instruction inputs are sampled at the end of each tick-high cycle.
- R2: In the tick-low cycle after an instruction is sampled with `instr_valid`=1, each group raises `mem_rd_en[g]` with its effective source address on `mem_rd_addr[g]`. `mem_rd_en` is never high in a tick-high cycle.
- R3: When `instr_indep`=0, every group uses slice 0 of `instr_src`, `instr_dst` and `instr_op` (bits [AW-1:0] and [OPW-1:0]). When `instr_indep`=1, group g uses slice g (bits [g*AW +: AW] and [g*OPW +: OPW]).
- R4: The memory returns data one clock after a read. Throughout the next slow cycle, `pe_valid[g]` is 1, `pe_op[g]` is the effective operation, and `pe_opnd[g]` is the returned word. These outputs do not change within a slow cycle.
- R5: `pe_res[g]` is sampled at the end of the tick-high cycle of the execute slow cycle. In the tick-high cycle of the following slow cycle, `mem_wr_en[g]` is 1, `mem_wr_addr[g]` is the effective destination and `mem_wr_data[g]` is the sampled word. `mem_wr_en` is never high in a tick-low cycle.
- R6: A read for one instruction and the write-back of the instruction issued two slow cycles earlier fall in the same slow cycle, with the read first. When both use the same address, the read returns the value from before that write, and the next instruction reads the written value.
- R7: A slot sampled with `instr_valid`=0 produces no read, a low `pe_valid` and no write, whatever its other fields hold.
- R8: Asserting `rst_n` clears `mem_rd_en`, `mem_wr_en` and `pe_valid` at once. No instruction that was in flight at reset is read, presented or written after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (twice the instruction rate) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction slot carries work |
| instr_indep | input | 1 | 1: each group uses its own fields; 0: all use slice 0 |
| instr_src | input | GROUPS*AW | Per-group operand source addresses |
| instr_dst | input | GROUPS*AW | Per-group result destination addresses |
| instr_op | input | GROUPS*OPW | Per-group operation codes |
| mstr_tick | output | 1 | High in the store half of each slow cycle |
| mem_rd_en | output | GROUPS | Per-group memory read strobe |
| mem_rd_addr | output | GROUPS*AW | Per-group read address |
| mem_rd_data | input | GROUPS*LANES*DW | Per-group read data, one cycle after the strobe |
| mem_wr_en | output | GROUPS | Per-group memory write strobe |
| mem_wr_addr | output | GROUPS*AW | Per-group write address |
| mem_wr_data | output | GROUPS*LANES*DW | Per-group write data |
| pe_valid | output | GROUPS | Operands and operation valid for the group |
| pe_op | output | GROUPS*OPW | Operation broadcast to the group's elements |
| pe_opnd | output | GROUPS*LANES*DW | Operand word, one lane per element |
| pe_res | input | GROUPS*LANES*DW | Result word from the group's elements |

## Verification
The read for a new instruction and the write-back of an older result always share a slow cycle, so the interesting case is when both target the same address. A directed sequence issues a write to one address and, two and three slots later, reads from it. Random traffic over only eight addresses repeats that collision many times. The bench keeps a shadow memory that it updates only at the moments the store halves should write. The operand presented to the elements must match the shadow content as it stood at the fetch half, which shows the pre-write value for the colliding read and the new value one slot later.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  // Half of a slow cycle: operands are fetched first, results stored second.
  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_STORE = 1'b1
  } phase_e;

endpackage

// File: rtl/opseq_rst_sync.sv
module opseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ni = sync_q[STAGES-1];

endmodule

// File: rtl/opseq_master.sv
module opseq_master
  import opseq_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int AW     = 8,
  parameter int OPW    = 4
) (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic                         instr_valid,
  input  logic                         instr_indep,
  input  logic [GROUPS-1:0][AW-1:0]    instr_src,
  input  logic [GROUPS-1:0][AW-1:0]    instr_dst,
  input  logic [GROUPS-1:0][OPW-1:0]   instr_op,
  output phase_e                       phase,
  output logic                         adv,
  output logic [GROUPS-1:0]            iss_valid,
  output logic [GROUPS-1:0][AW-1:0]    iss_src,
  output logic [GROUPS-1:0][AW-1:0]    iss_dst,
  output logic [GROUPS-1:0][OPW-1:0]   iss_op
);

  phase_e                      phase_q, phase_d;
  logic [GROUPS-1:0]           valid_q, valid_d;
  logic [GROUPS-1:0][AW-1:0]   src_q, src_d;
  logic [GROUPS-1:0][AW-1:0]   dst_q, dst_d;
  logic [GROUPS-1:0][OPW-1:0]  op_q, op_d;

  // Per-group field selection according to the mode bit.
  logic [GROUPS-1:0][AW-1:0]   route_src;
  logic [GROUPS-1:0][AW-1:0]   route_dst;
  logic [GROUPS-1:0][OPW-1:0]  route_op;

  for (genvar g = 0; g < GROUPS; g++) begin : g_route
    assign route_src[g] = instr_indep ? instr_src[g] : instr_src[0];
    assign route_dst[g] = instr_indep ? instr_dst[g] : instr_dst[0];
    assign route_op[g]  = instr_indep ? instr_op[g]  : instr_op[0];
  end

  // The master stage moves only at the end of the store half.
  assign adv = (phase_q == PH_STORE);

  always_comb begin
    phase_d = (phase_q == PH_FETCH) ? PH_STORE : PH_FETCH;
    valid_d = valid_q;
    src_d   = src_q;
    dst_d   = dst_q;
    op_d    = op_q;
    if (adv) begin
      valid_d = {GROUPS{instr_valid}};
      src_d   = route_src;
      dst_d   = route_dst;
      op_d    = route_op;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
      valid_q <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      op_q    <= '0;
    end else begin
      phase_q <= phase_d;
      valid_q <= valid_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      op_q    <= op_d;
    end
  end

  assign phase     = phase_q;
  assign iss_valid = valid_q;
  assign iss_src   = src_q;
  assign iss_dst   = dst_q;
  assign iss_op    = op_q;

endmodule

// File: rtl/opseq_slave.sv
module opseq_slave
  import opseq_pkg::*;
#(
  parameter int AW   = 8,
  parameter int OPW  = 4,
  parameter int WORD = 48
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  phase_e          phase,
  input  logic            adv,
  input  logic            iss_valid,
  input  logic [AW-1:0]   iss_src,
  input  logic [AW-1:0]   iss_dst,
  input  logic [OPW-1:0]  iss_op,
  output logic            mem_rd_en,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic [WORD-1:0] mem_rd_data,
  output logic            mem_wr_en,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [WORD-1:0] mem_wr_data,
  output logic            pe_valid,
  output logic [OPW-1:0]  pe_op,
  output logic [WORD-1:0] pe_opnd,
  input  logic [WORD-1:0] pe_res
);

  // Execute stage: what the elements work on during this slow cycle.
  logic            x_valid_q, x_valid_d;
  logic [AW-1:0]   x_dst_q, x_dst_d;
  logic [OPW-1:0]  x_op_q, x_op_d;
  logic [WORD-1:0] x_opnd_q, x_opnd_d;

  // Store stage: result waiting for the store half.
  logic            w_valid_q, w_valid_d;
  logic [AW-1:0]   w_dst_q, w_dst_d;
  logic [WORD-1:0] w_data_q, w_data_d;

  // Fetch half: read the operand word of the issued instruction.
  assign mem_rd_en   = iss_valid && (phase == PH_FETCH);
  assign mem_rd_addr = iss_src;

  always_comb begin
    x_valid_d = x_valid_q;
    x_dst_d   = x_dst_q;
    x_op_d    = x_op_q;
    x_opnd_d  = x_opnd_q;
    w_valid_d = w_valid_q;
    w_dst_d   = w_dst_q;
    w_data_d  = w_data_q;
    if (adv) begin
      x_valid_d = iss_valid;
      x_dst_d   = iss_dst;
      x_op_d    = iss_op;
      if (iss_valid) begin
        x_opnd_d = mem_rd_data;
      end
      w_valid_d = x_valid_q;
      w_dst_d   = x_dst_q;
      if (x_valid_q) begin
        w_data_d = pe_res;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      x_valid_q <= 1'b0;
      x_dst_q   <= '0;
      x_op_q    <= '0;
      x_opnd_q  <= '0;
      w_valid_q <= 1'b0;
      w_dst_q   <= '0;
      w_data_q  <= '0;
    end else begin
      x_valid_q <= x_valid_d;
      x_dst_q   <= x_dst_d;
      x_op_q    <= x_op_d;
      x_opnd_q  <= x_opnd_d;
      w_valid_q <= w_valid_d;
      w_dst_q   <= w_dst_d;
      w_data_q  <= w_data_d;
    end
  end

  assign pe_valid = x_valid_q;
  assign pe_op    = x_op_q;
  assign pe_opnd  = x_opnd_q;

  // Store half: write the result of the previous execute cycle.
  assign mem_wr_en   = w_valid_q && (phase == PH_STORE);
  assign mem_wr_addr = w_dst_q;
  assign mem_wr_data = w_data_q;

endmodule

// File: rtl/opseq_dual_rate.sv
module opseq_dual_rate
  import opseq_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int LANES  = 3,
  parameter int DW     = 16,
  parameter int AW     = 8,
  parameter int OPW    = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 instr_valid,
  input  logic                                 instr_indep,
  input  logic [GROUPS-1:0][AW-1:0]            instr_src,
  input  logic [GROUPS-1:0][AW-1:0]            instr_dst,
  input  logic [GROUPS-1:0][OPW-1:0]           instr_op,
  output logic                                 mstr_tick,
  output logic [GROUPS-1:0]                    mem_rd_en,
  output logic [GROUPS-1:0][AW-1:0]            mem_rd_addr,
  input  logic [GROUPS-1:0][LANES*DW-1:0]      mem_rd_data,
  output logic [GROUPS-1:0]                    mem_wr_en,
  output logic [GROUPS-1:0][AW-1:0]            mem_wr_addr,
  output logic [GROUPS-1:0][LANES*DW-1:0]      mem_wr_data,
  output logic [GROUPS-1:0]                    pe_valid,
  output logic [GROUPS-1:0][OPW-1:0]           pe_op,
  output logic [GROUPS-1:0][LANES*DW-1:0]      pe_opnd,
  input  logic [GROUPS-1:0][LANES*DW-1:0]      pe_res
);

  localparam int WORD = LANES * DW;

  logic                        rst_ni;
  phase_e                      phase;
  logic                        adv;
  logic [GROUPS-1:0]           iss_valid;
  logic [GROUPS-1:0][AW-1:0]   iss_src;
  logic [GROUPS-1:0][AW-1:0]   iss_dst;
  logic [GROUPS-1:0][OPW-1:0]  iss_op;

  opseq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  opseq_master #(
    .GROUPS (GROUPS),
    .AW     (AW),
    .OPW    (OPW)
  ) i_master (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .instr_valid (instr_valid),
    .instr_indep (instr_indep),
    .instr_src   (instr_src),
    .instr_dst   (instr_dst),
    .instr_op    (instr_op),
    .phase       (phase),
    .adv         (adv),
    .iss_valid   (iss_valid),
    .iss_src     (iss_src),
    .iss_dst     (iss_dst),
    .iss_op      (iss_op)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_slave
    opseq_slave #(
      .AW   (AW),
      .OPW  (OPW),
      .WORD (WORD)
    ) i_slave (
      .clk         (clk),
      .rst_ni      (rst_ni),
      .phase       (phase),
      .adv         (adv),
      .iss_valid   (iss_valid[g]),
      .iss_src     (iss_src[g]),
      .iss_dst     (iss_dst[g]),
      .iss_op      (iss_op[g]),
      .mem_rd_en   (mem_rd_en[g]),
      .mem_rd_addr (mem_rd_addr[g]),
      .mem_rd_data (mem_rd_data[g]),
      .mem_wr_en   (mem_wr_en[g]),
      .mem_wr_addr (mem_wr_addr[g]),
      .mem_wr_data (mem_wr_data[g]),
      .pe_valid    (pe_valid[g]),
      .pe_op       (pe_op[g]),
      .pe_opnd     (pe_opnd[g]),
      .pe_res      (pe_res[g])
    );
  end

  assign mstr_tick = (phase == PH_STORE);

endmodule

// File: rtl/opseq_dual_rate_chk.sv
module opseq_dual_rate_chk #(
  parameter int GROUPS = 2,
  parameter int AW     = 8,
  parameter int WORD   = 48
) (
  input logic                            clk,
  input logic                            rst_ni,
  input logic                            mstr_tick,
  input logic                            instr_indep,
  input logic [GROUPS-1:0]               mem_rd_en,
  input logic [GROUPS-1:0][AW-1:0]       mem_rd_addr,
  input logic [GROUPS-1:0]               mem_wr_en,
  input logic [GROUPS-1:0][WORD-1:0]     mem_wr_data,
  input logic [GROUPS-1:0]               pe_valid,
  input logic [GROUPS-1:0][WORD-1:0]     pe_res
);

  // R1: tick alternates once the internal reset is released
  assert_tick_rise_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !mstr_tick |=> mstr_tick) else $error("tick did not rise");
  assert_tick_fall_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    mstr_tick |=> !mstr_tick) else $error("tick did not fall");

  // R3: shared mode gives every group the slice-0 source address
  assert_shared_route_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_rd_en[0] && !$past(instr_indep)) |-> (mem_rd_en[1] && mem_rd_addr[1] == mem_rd_addr[0]))
    else $error("shared mode routing broken");

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    // R2: reads only in the fetch half
    assert_rd_phase_R2: assert property (@(posedge clk) disable iff (!rst_ni)
      mem_rd_en[g] |-> !mstr_tick) else $error("read in store half");
    // R5: writes only in the store half
    assert_wr_phase_R5: assert property (@(posedge clk) disable iff (!rst_ni)
      mem_wr_en[g] |-> mstr_tick) else $error("write in fetch half");
    // R4: a read leads to valid operands one slow cycle later
    assert_rd_to_pe_R4: assert property (@(posedge clk) disable iff (!rst_ni)
      mem_rd_en[g] |=> ##1 pe_valid[g]) else $error("read not presented");
    // R4: element outputs hold across the fetch-to-store boundary
    assert_pe_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
      !mstr_tick |=> $stable(pe_valid[g])) else $error("pe_valid changed mid slot");
    // R5: a write carries the result sampled one slow cycle earlier
    assert_wr_source_R5: assert property (@(posedge clk) disable iff (!rst_ni)
      mem_wr_en[g] |-> ($past(pe_valid[g], 2) && mem_wr_data[g] == $past(pe_res[g], 2)))
      else $error("write data not from sampled result");
    // R7: an empty execute slot never produces a write
    assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_ni)
      (mstr_tick && !pe_valid[g]) |-> ##2 !mem_wr_en[g]) else $error("bubble wrote");
  end

endmodule

bind opseq_dual_rate opseq_dual_rate_chk #(
  .GROUPS (GROUPS),
  .AW     (AW),
  .WORD   (WORD)
) i_chk (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .mstr_tick   (mstr_tick),
  .instr_indep (instr_indep),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_data (mem_wr_data),
  .pe_valid    (pe_valid),
  .pe_res      (pe_res)
);

// File: tb/test_opseq_dual_rate.sv
module test_opseq_dual_rate;

  localparam int G    = 2;
  localparam int L    = 3;
  localparam int DW   = 16;
  localparam int AW   = 8;
  localparam int OPW  = 4;
  localparam int WORD = L * DW;

  logic                    clk;
  logic                    rst_n;
  logic                    instr_valid;
  logic                    instr_indep;
  logic [G-1:0][AW-1:0]    instr_src;
  logic [G-1:0][AW-1:0]    instr_dst;
  logic [G-1:0][OPW-1:0]   instr_op;
  logic                    mstr_tick;
  logic [G-1:0]            mem_rd_en;
  logic [G-1:0][AW-1:0]    mem_rd_addr;
  logic [G-1:0][WORD-1:0]  mem_rd_data;
  logic [G-1:0]            mem_wr_en;
  logic [G-1:0][AW-1:0]    mem_wr_addr;
  logic [G-1:0][WORD-1:0]  mem_wr_data;
  logic [G-1:0]            pe_valid;
  logic [G-1:0][OPW-1:0]   pe_op;
  logic [G-1:0][WORD-1:0]  pe_opnd;
  logic [G-1:0][WORD-1:0]  pe_res;

  opseq_dual_rate #(.GROUPS(G), .LANES(L), .DW(DW), .AW(AW), .OPW(OPW)) i_opseq_dual_rate (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_indep(instr_indep),
    .instr_src(instr_src), .instr_dst(instr_dst), .instr_op(instr_op), .mstr_tick(mstr_tick),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .pe_valid(pe_valid), .pe_op(pe_op), .pe_opnd(pe_opnd), .pe_res(pe_res)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  function automatic logic [WORD-1:0] init_word(input int g, input int a);
    logic [WORD-1:0] w;
    for (int l = 0; l < L; l++) w[l*DW +: DW] = 16'(a * 5 + l * 11 + g * 97 + 256);
    return w;
  endfunction

  function automatic logic [WORD-1:0] pe_fn(input logic [WORD-1:0] w, input logic [OPW-1:0] op, input int g);
    logic [WORD-1:0] r;
    for (int l = 0; l < L; l++) r[l*DW +: DW] = 16'(w[l*DW +: DW] * 3 + op + l + g * 7);
    return r;
  endfunction

  // Element model
  always_comb begin
    for (int g = 0; g < G; g++) pe_res[g] = pe_fn(pe_opnd[g], pe_op[g], g);
  end

  // Memory model, one cycle read latency
  logic [WORD-1:0] mem [G][256];
  initial begin
    for (int g = 0; g < G; g++)
      for (int a = 0; a < 256; a++) mem[g][a] = init_word(g, a);
    forever begin
      @(posedge clk);
      for (int g = 0; g < G; g++) begin
        if (mem_rd_en[g]) mem_rd_data[g] <= mem[g][mem_rd_addr[g]];
        if (mem_wr_en[g]) mem[g][mem_wr_addr[g]] <= mem_wr_data[g];
      end
    end
  end

  // Bench reference state
  logic [WORD-1:0] shadow [G][256];
  logic            rv    [4];
  logic [AW-1:0]   rsrc  [4][G];
  logic [AW-1:0]   rdst  [4][G];
  logic [OPW-1:0]  rop   [4][G];
  logic [WORD-1:0] ropnd [4][G];
  int sn = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_pe(input int idx);
    for (int g = 0; g < G; g++) begin
      chk("R4", "pe_valid", 64'(pe_valid[g]), 64'(rv[idx]));
      if (rv[idx]) begin
        chk("R4", "pe_op", 64'(pe_op[g]), 64'(rop[idx][g]));
        chk("R4", "pe_opnd", 64'(pe_opnd[g]), 64'(ropnd[idx][g]));
      end
    end
  endtask

  // Runs one slow cycle starting at the negedge inside its fetch half.
  task automatic slow_cycle(input logic v, input logic ind,
                            input logic [G-1:0][AW-1:0] s_src, input logic [G-1:0][AW-1:0] s_dst,
                            input logic [G-1:0][OPW-1:0] s_op);
    int pr  = (sn + 3) % 4;
    int px  = (sn + 2) % 4;
    int pw  = (sn + 1) % 4;
    int cur = sn % 4;
    chk("R1", "tick fetch half", 64'(mstr_tick), 64'd0);
    for (int g = 0; g < G; g++) begin
      chk("R2", "rd_en fetch half", 64'(mem_rd_en[g]), 64'(rv[pr]));
      if (rv[pr]) begin
        chk("R3", "rd_addr", 64'(mem_rd_addr[g]), 64'(rsrc[pr][g]));
        ropnd[pr][g] = shadow[g][rsrc[pr][g]];
      end
      chk("R5", "wr_en fetch half", 64'(mem_wr_en[g]), 64'd0);
    end
    check_pe(px);
    @(negedge clk);
    chk("R1", "tick store half", 64'(mstr_tick), 64'd1);
    for (int g = 0; g < G; g++) begin
      chk("R2", "rd_en store half", 64'(mem_rd_en[g]), 64'd0);
      chk("R7", "wr_en store half", 64'(mem_wr_en[g]), 64'(rv[pw]));
      if (rv[pw]) begin
        chk("R5", "wr_addr", 64'(mem_wr_addr[g]), 64'(rdst[pw][g]));
        chk("R5", "wr_data", 64'(mem_wr_data[g]), 64'(pe_fn(ropnd[pw][g], rop[pw][g], g)));
        shadow[g][rdst[pw][g]] = pe_fn(ropnd[pw][g], rop[pw][g], g);
      end
    end
    check_pe(px);
    instr_valid = v;
    instr_indep = ind;
    instr_src   = s_src;
    instr_dst   = s_dst;
    instr_op    = s_op;
    rv[cur] = v;
    for (int g = 0; g < G; g++) begin
      int sel = ind ? g : 0;
      rsrc[cur][g] = s_src[sel];
      rdst[cur][g] = s_dst[sel];
      rop[cur][g]  = s_op[sel];
    end
    @(negedge clk);
    sn++;
  endtask

  task automatic nop_cycle();
    slow_cycle(1'b0, 1'b1, {8'hEE, 8'hDD}, {8'hCC, 8'hBB}, {4'hA, 4'h9});
  endtask

  task automatic check_quiet(input string what);
    for (int g = 0; g < G; g++) begin
      chk("R8", {what, " rd_en"}, 64'(mem_rd_en[g]), 64'd0);
      chk("R8", {what, " wr_en"}, 64'(mem_wr_en[g]), 64'd0);
      chk("R8", {what, " pe_valid"}, 64'(pe_valid[g]), 64'd0);
    end
  endtask

  // Called at a negedge with rst_n low.
  task automatic release_align();
    instr_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "tick after release 1", 64'(mstr_tick), 64'd0);
    @(negedge clk);
    chk("R1", "tick after release 2", 64'(mstr_tick), 64'd0);
    @(negedge clk);
    chk("R1", "tick after release 3", 64'(mstr_tick), 64'd1);
    @(negedge clk);
    for (int i = 0; i < 4; i++) rv[i] = 1'b0;
    sn = 0;
  endtask

  initial begin
    logic [WORD-1:0] old_v, new_v;
    void'($urandom(32'd24680));
    rst_n = 1'b0;
    instr_valid = 1'b0;
    instr_indep = 1'b0;
    instr_src = '0;
    instr_dst = '0;
    instr_op = '0;
    for (int g = 0; g < G; g++)
      for (int a = 0; a < 256; a++) shadow[g][a] = init_word(g, a);
    repeat (3) @(negedge clk);
    chk("R1", "tick in reset", 64'(mstr_tick), 64'd0);
    check_quiet("in reset");
    release_align();

    // Directed: shared mode, then independent mode
    slow_cycle(1'b1, 1'b0, {8'd40, 8'd3}, {8'd41, 8'd20}, {4'd9, 4'd2});
    slow_cycle(1'b1, 1'b1, {8'd50, 8'd4}, {8'd51, 8'd21}, {4'd7, 4'd5});
    nop_cycle();
    nop_cycle();
    nop_cycle();

    // Directed R6 collision: A writes 5, B reads 5 in A's write slot, C reads 5 after
    slow_cycle(1'b1, 1'b0, {8'd0, 8'd1}, {8'd0, 8'd5}, {4'd0, 4'd3});
    nop_cycle();
    slow_cycle(1'b1, 1'b0, {8'd0, 8'd5}, {8'd0, 8'd9}, {4'd0, 4'd1});
    old_v = shadow[0][5];
    slow_cycle(1'b1, 1'b0, {8'd0, 8'd5}, {8'd0, 8'd10}, {4'd0, 4'd2});
    new_v = shadow[0][5];
    chk("R6", "collision read sees old", 64'(pe_opnd[0]), 64'(old_v));
    chk("R6", "write changed word", 64'(old_v != new_v), 64'd1);
    nop_cycle();
    chk("R6", "next read sees new", 64'(pe_opnd[0]), 64'(new_v));
    nop_cycle();
    nop_cycle();

    // Constrained random over a small address range
    for (int i = 0; i < 300; i++) begin
      logic [G-1:0][AW-1:0] s, d;
      logic [G-1:0][OPW-1:0] o;
      for (int g = 0; g < G; g++) begin
        s[g] = 8'($urandom_range(7));
        d[g] = 8'($urandom_range(7));
        o[g] = 4'($urandom_range(15));
      end
      slow_cycle($urandom_range(9) != 0, 1'($urandom_range(1)), s, d, o);
    end

    // R8: reset with work in flight
    slow_cycle(1'b1, 1'b1, {8'd2, 8'd3}, {8'd4, 8'd5}, {4'd1, 4'd2});
    slow_cycle(1'b1, 1'b0, {8'd6, 8'd7}, {8'd6, 8'd7}, {4'd3, 4'd4});
    rst_n = 1'b0;
    #1;
    check_quiet("at reset edge");
    chk("R8", "tick at reset", 64'(mstr_tick), 64'd0);
    repeat (3) @(negedge clk);
    release_align();
    for (int i = 0; i < 5; i++) nop_cycle();
    for (int i = 0; i < 40; i++) begin
      logic [G-1:0][AW-1:0] s, d;
      logic [G-1:0][OPW-1:0] o;
      for (int g = 0; g < G; g++) begin
        s[g] = 8'($urandom_range(7));
        d[g] = 8'($urandom_range(7));
        o[g] = 4'($urandom_range(15));
      end
      slow_cycle($urandom_range(3) != 0, 1'($urandom_range(1)), s, d, o);
    end
    for (int i = 0; i < 4; i++) nop_cycle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule